// File: doc/BRIEF.md
# Zero-Substitution Line Decoder (B3ZS / HDB3)

This block sits behind a dual-rail line receiver. It takes one positive and one negative rail bit per clock and undoes the zero substitutions made by the far-end encoder. A mode input selects the three-zero code, B3ZS, or the four-zero code, HDB3. Substitution patterns are recognised inside a short delay pipeline. The substituted marks are turned back into spaces before the bit leaves the block. The block outputs the decoded rails, a merged NRZ data bit and a one-bit error flag. The flag is raised for marks that break the alternate-polarity rule outside a legal substitution, and for other coding errors.

A bypass input skips decoding. The rails then pass through on a short path, and every polarity repeat is flagged. A loopback select takes the input from the local transmit encoder's rails instead of the line. The block runs on a single rising-edge clock with a synchronous active-high reset. The falling-edge capture of the receive clock and the output clock inversion are left to the surrounding clocking logic.

Top module: `zs_decoder`

## Requirements
- R1: With `mode_b3zs`=1 and bypass low, a mark with the same polarity as the previous mark, coming right after one space, is removed. For the form mark-space-mark, the mark two bits earlier is removed as well. The three bits come out as spaces and no flag is raised. A mark is pos=1/neg=0 (positive) or pos=0/neg=1 (negative). A space is pos=0/neg=0.
- R2: With `mode_b3zs`=0 and bypass low, a same-polarity mark coming right after two spaces is removed. For the form mark-space-space-mark, the mark three bits earlier is removed as well. The four bits come out as spaces and no flag is raised.
- R3: With bypass low, a same-polarity mark that lacks the spaces its mode requires is passed through unchanged on its rails and flagged.
- R4: A bit with both rails high is passed through unchanged and flagged, in both decode and bypass modes. It does not change the stored polarity.
- R5: With bypass low, a run of spaces longer than the substitution length (4 spaces in B3ZS, 5 in HDB3) raises the flag once, on the space that makes the run too long. Spaces before the first mark after reset never raise it.
- R6: With bypass high, the output rails equal the input rails, and every mark with the same polarity as the previous mark is flagged. Zero runs are not checked in this mode.
- R7: Latency from the capturing clock edge to the output is 7 edges with decoding on and 2 edges with bypass on. The flag is aligned with the output bit that carries the offending bit.
- R8: `dec_nrz` equals the OR of `dec_pos` and `dec_neg` for every output bit.
- R9: With `loop_en`=1 the block decodes `loop_pos`/`loop_neg` and ignores `line_pos`/`line_neg`. With `loop_en`=0 it does the reverse.
- R10: Reset drives all outputs low and clears the stored polarity. The first mark after reset is never treated as a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_b3zs | input | 1 | 1 selects B3ZS, 0 selects HDB3 |
| dec_bypass | input | 1 | 1 bypasses decoding |
| loop_en | input | 1 | 1 selects the loopback rails as input |
| line_pos | input | 1 | Positive rail from the line receiver |
| line_neg | input | 1 | Negative rail from the line receiver |
| loop_pos | input | 1 | Positive rail from the local encoder |
| loop_neg | input | 1 | Negative rail from the local encoder |
| dec_pos | output | 1 | Decoded positive rail |
| dec_neg | output | 1 | Decoded negative rail |
| dec_nrz | output | 1 | OR of the decoded rails |
| viol | output | 1 | One-bit violation / coding-error flag |

## Verification
The bench targets the patterns that tell a real substitution apart from a bad one.

- **Same mark, two modes.** A mark-space-mark pair is legal in B3ZS but is an error in HDB3. A decoder that checks the spacing against the wrong mode either deletes real data or misses the error.
- **Preceding mark removal.** In the mark-space(-space)-mark forms, the earlier mark must also vanish. A decoder that clears only the final mark leaves a stray one on the data output.
- **Run-length edge.** Zero runs are tested exactly at the substitution length and one past it. An off-by-one counter either floods the flag or stays silent.
- **Reset and bypass.** A mark arriving after reset must not be judged against stale polarity; a decoder that keeps the old polarity deletes it or flags it. Bypass streams confirm that nothing is rewritten and that every repeat is flagged.

// File: rtl/zs_decoder_pkg.sv
package zs_decoder_pkg;

  // one bit position travelling through the delay line
  typedef struct packed {
    logic p;
    logic n;
    logic err;
  } lane_t;

  function automatic logic is_mark(input logic p, input logic n);
    return p ^ n;
  endfunction

  function automatic logic is_space(input logic p, input logic n);
    return ~(p | n);
  endfunction

endpackage

// File: rtl/zs_rx_front.sv
// Input selection and capture register (first latency edge).
module zs_rx_front (
  input  logic clk,
  input  logic rst,
  input  logic loop_en,
  input  logic line_pos,
  input  logic line_neg,
  input  logic loop_pos,
  input  logic loop_neg,
  output logic cap_p,
  output logic cap_n
);

  logic sel_p;
  logic sel_n;

  always_comb begin
    sel_p = loop_en ? loop_pos : line_pos;
    sel_n = loop_en ? loop_neg : line_neg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_p <= 1'b0;
      cap_n <= 1'b0;
    end else begin
      cap_p <= sel_p;
      cap_n <= sel_n;
    end
  end

endmodule

// File: rtl/zs_classify.sv
// Polarity tracking, substitution recognition and error classification
// for the bit currently held in the capture register.
module zs_classify
  import zs_decoder_pkg::*;
#(
  parameter int B3_RUN = 3,
  parameter int HD_RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_b3zs,
  input  logic cur_p,
  input  logic cur_n,
  input  logic h1_p,
  input  logic h1_n,
  input  logic h2_p,
  input  logic h2_n,
  input  logic h3_p,
  input  logic h3_n,
  output logic sub_hit,
  output logic clr_at2,
  output logic clr_at3,
  output logic flag_en,
  output logic flag_byp
);

  localparam int ZW = $clog2(((B3_RUN > HD_RUN) ? B3_RUN : HD_RUN) + 2);

  logic          have_mark;
  logic          last_pos;
  logic [ZW-1:0] zrun;

  logic          cur_mark;
  logic          cur_both;
  logic          cur_zero;
  logic          repeat_pol;
  logic          gap_ok;
  logic [ZW-1:0] run_lim;
  logic          run_err;

  always_comb begin
    cur_mark   = is_mark(cur_p, cur_n);
    cur_both   = cur_p & cur_n;
    cur_zero   = is_space(cur_p, cur_n);
    repeat_pol = cur_mark & have_mark & (cur_p == last_pos);
    gap_ok     = mode_b3zs ? is_space(h1_p, h1_n)
                           : (is_space(h1_p, h1_n) & is_space(h2_p, h2_n));
    sub_hit    = repeat_pol & gap_ok;
    clr_at2    = sub_hit &  mode_b3zs & is_mark(h2_p, h2_n);
    clr_at3    = sub_hit & ~mode_b3zs & is_mark(h3_p, h3_n);
    run_lim    = mode_b3zs ? ZW'(B3_RUN) : ZW'(HD_RUN);
    run_err    = cur_zero & have_mark & (zrun == run_lim);
    flag_en    = (repeat_pol & ~gap_ok) | cur_both | run_err;
    flag_byp   = repeat_pol | cur_both;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_mark <= 1'b0;
      last_pos  <= 1'b0;
      zrun      <= '0;
    end else begin
      if (cur_mark) begin
        have_mark <= 1'b1;
        last_pos  <= cur_p;
      end
      if (!cur_zero) begin
        zrun <= '0;
      end else if (zrun <= run_lim) begin
        zrun <= zrun + 1'b1;
      end
    end
  end

endmodule

// File: rtl/zs_window.sv
// Delay line holding recent bits; clears substituted marks in place.
module zs_window
  import zs_decoder_pkg::*;
#(
  parameter int WIN = 5
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  cur_p,
  input  logic  cur_n,
  input  logic  sub_hit,
  input  logic  flag_en,
  input  logic  clr_at2,
  input  logic  clr_at3,
  output logic  h1_p,
  output logic  h1_n,
  output logic  h2_p,
  output logic  h2_n,
  output logic  h3_p,
  output logic  h3_n,
  output lane_t tail
);

  // WIN must be at least 4 so the leading mark of a four-bit
  // substitution is still inside the line when it is cleared.
  lane_t w [WIN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN; i++) w[i] <= '0;
    end else begin
      w[0].p   <= cur_p & ~sub_hit;
      w[0].n   <= cur_n & ~sub_hit;
      w[0].err <= flag_en;
      for (int i = 1; i < WIN; i++) begin
        w[i].p   <= w[i-1].p & ~(((i == 2) & clr_at2) | ((i == 3) & clr_at3));
        w[i].n   <= w[i-1].n & ~(((i == 2) & clr_at2) | ((i == 3) & clr_at3));
        w[i].err <= w[i-1].err;
      end
    end
  end

  always_comb begin
    h1_p = w[0].p;
    h1_n = w[0].n;
    h2_p = w[1].p;
    h2_n = w[1].n;
    h3_p = w[2].p;
    h3_n = w[2].n;
    tail = w[WIN-1];
  end

endmodule

// File: rtl/zs_decoder.sv
module zs_decoder
  import zs_decoder_pkg::*;
#(
  parameter int EN_LAT = 7,
  parameter int B3_RUN = 3,
  parameter int HD_RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_b3zs,
  input  logic dec_bypass,
  input  logic loop_en,
  input  logic line_pos,
  input  logic line_neg,
  input  logic loop_pos,
  input  logic loop_neg,
  output logic dec_pos,
  output logic dec_neg,
  output logic dec_nrz,
  output logic viol
);

  // capture edge + output edge surround the delay line
  localparam int WIN = EN_LAT - 2;

  logic  cap_p, cap_n;
  logic  h1_p, h1_n, h2_p, h2_n, h3_p, h3_n;
  logic  sub_hit, clr_at2, clr_at3, flag_en, flag_byp;
  lane_t tail;

  zs_rx_front front_i (
    .clk      (clk),
    .rst      (rst),
    .loop_en  (loop_en),
    .line_pos (line_pos),
    .line_neg (line_neg),
    .loop_pos (loop_pos),
    .loop_neg (loop_neg),
    .cap_p    (cap_p),
    .cap_n    (cap_n)
  );

  zs_classify #(
    .B3_RUN (B3_RUN),
    .HD_RUN (HD_RUN)
  ) class_i (
    .clk       (clk),
    .rst       (rst),
    .mode_b3zs (mode_b3zs),
    .cur_p     (cap_p),
    .cur_n     (cap_n),
    .h1_p      (h1_p),
    .h1_n      (h1_n),
    .h2_p      (h2_p),
    .h2_n      (h2_n),
    .h3_p      (h3_p),
    .h3_n      (h3_n),
    .sub_hit   (sub_hit),
    .clr_at2   (clr_at2),
    .clr_at3   (clr_at3),
    .flag_en   (flag_en),
    .flag_byp  (flag_byp)
  );

  zs_window #(
    .WIN (WIN)
  ) win_i (
    .clk     (clk),
    .rst     (rst),
    .cur_p   (cap_p),
    .cur_n   (cap_n),
    .sub_hit (sub_hit),
    .flag_en (flag_en),
    .clr_at2 (clr_at2),
    .clr_at3 (clr_at3),
    .h1_p    (h1_p),
    .h1_n    (h1_n),
    .h2_p    (h2_p),
    .h2_n    (h2_n),
    .h3_p    (h3_p),
    .h3_n    (h3_n),
    .tail    (tail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_pos <= 1'b0;
      dec_neg <= 1'b0;
      dec_nrz <= 1'b0;
      viol    <= 1'b0;
    end else if (dec_bypass) begin
      dec_pos <= cap_p;
      dec_neg <= cap_n;
      dec_nrz <= cap_p | cap_n;
      viol    <= flag_byp;
    end else begin
      dec_pos <= tail.p;
      dec_neg <= tail.n;
      dec_nrz <= tail.p | tail.n;
      viol    <= tail.err;
    end
  end

endmodule

// File: rtl/zs_decoder_chk.sv
module zs_decoder_chk (
  input logic clk,
  input logic rst,
  input logic dec_bypass,
  input logic loop_en,
  input logic line_pos,
  input logic line_neg,
  input logic loop_pos,
  input logic loop_neg,
  input logic dec_pos,
  input logic dec_neg,
  input logic dec_nrz,
  input logic viol
);

  logic [2:0] age;

  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dec_pos && !dec_neg && !dec_nrz && !viol));

  // R6
  byp_line_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd2 && $past(dec_bypass) && !$past(loop_en, 2))
      |-> (dec_pos == $past(line_pos, 2) && dec_neg == $past(line_neg, 2)));

  // R9
  byp_loop_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd2 && $past(dec_bypass) && $past(loop_en, 2))
      |-> (dec_pos == $past(loop_pos, 2) && dec_neg == $past(loop_neg, 2)));

  // R8
  byp_nrz_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd2 && $past(dec_bypass) && !$past(loop_en, 2))
      |-> (dec_nrz == ($past(line_pos, 2) | $past(line_neg, 2))));

  // R4
  byp_both_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd2 && $past(dec_bypass) && !$past(loop_en, 2) &&
     $past(line_pos, 2) && $past(line_neg, 2)) |-> viol);

endmodule

bind zs_decoder zs_decoder_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .dec_bypass (dec_bypass),
  .loop_en    (loop_en),
  .line_pos   (line_pos),
  .line_neg   (line_neg),
  .loop_pos   (loop_pos),
  .loop_neg   (loop_neg),
  .dec_pos    (dec_pos),
  .dec_neg    (dec_neg),
  .dec_nrz    (dec_nrz),
  .viol       (viol)
);

// File: tb/zs_decoder_tb_top.sv
`timescale 1ns/1ps
module zs_decoder_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_b3zs = 1'b1, dec_bypass = 1'b0, loop_en = 1'b0;
  logic line_pos = 1'b0, line_neg = 1'b0, loop_pos = 1'b0, loop_neg = 1'b0;
  logic dec_pos, dec_neg, dec_nrz, viol;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  zs_decoder dut_i (
    .clk (clk), .rst (rst), .mode_b3zs (mode_b3zs), .dec_bypass (dec_bypass),
    .loop_en (loop_en), .line_pos (line_pos), .line_neg (line_neg),
    .loop_pos (loop_pos), .loop_neg (loop_neg), .dec_pos (dec_pos),
    .dec_neg (dec_neg), .dec_nrz (dec_nrz), .viol (viol)
  );

  // time runs left to right: cycle k is bit [15-k]
  typedef struct packed {
    logic        b3;
    logic        byp;
    logic        lp;
    logic [15:0] ip;
    logic [15:0] inn;
    logic [15:0] ep;
    logic [15:0] en;
    logic [15:0] ev;
  } seg_t;

  localparam int NSEG = 7;
  localparam seg_t SEGS [NSEG] = '{
    // R1 B3ZS: 00V at t4, B0V at t5/t7
    '{1'b1, 1'b0, 1'b0, 16'b1000010101001001, 16'b0100100010100100,
      16'b1000000001001001, 16'b0100000010100100, 16'b0000000000000000},
    // R2 HDB3: 000V at t4 and t14, B00V at t5/t8
    '{1'b0, 1'b0, 1'b0, 16'b1000100001000001, 16'b0000010010100010,
      16'b1000000001000001, 16'b0000000000100000, 16'b0000000000000000},
    // R3 R4 R5 B3ZS: bad repeats t1 t4, both-high t5, 4th space t9
    '{1'b1, 1'b0, 1'b0, 16'b1100010000010100, 16'b0001110000000000,
      16'b1100010000000000, 16'b0001110000000000, 16'b0100110001000000},
    // R3 R5 HDB3: 5th space t5, mark-space-mark t8 flagged, 000V t14
    '{1'b0, 1'b0, 1'b0, 16'b0000001010000000, 16'b1000000001000010,
      16'b0000001010000000, 16'b1000000001000000, 16'b0000010010000000},
    // R6 bypass: rails pass, repeats flagged
    '{1'b1, 1'b1, 1'b0, 16'b1000010101001001, 16'b0100100010100100,
      16'b1000010101001001, 16'b0100100010100100, 16'b0000100100000000},
    // R9 loopback, HDB3 decode
    '{1'b0, 1'b0, 1'b1, 16'b1000100001000001, 16'b0000010010100010,
      16'b1000000001000001, 16'b0000000000100000, 16'b0000000000000000},
    // R9 R6 R4 loopback with bypass
    '{1'b1, 1'b1, 1'b1, 16'b1100010000010100, 16'b0001110000000000,
      16'b1100010000010100, 16'b0001110000000000, 16'b0100110000000100}
  };

  function automatic string seg_tag(input int i);
    case (i)
      0: return "R1";
      1: return "R2";
      2: return "R3/R4/R5";
      3: return "R3/R5";
      4: return "R6";
      5: return "R9";
      default: return "R9/R6";
    endcase
  endfunction

  task automatic drive_bit(input logic lp, input logic p, input logic n);
    if (lp) begin
      loop_pos = p;   loop_neg = n;
      line_pos = 1'b1; line_neg = 1'b1;
    end else begin
      line_pos = p;   line_neg = n;
      loop_pos = 1'b1; loop_neg = 1'b1;
    end
  endtask

  task automatic run_stream(input seg_t s, input string tag);
    int lat;
    lat = s.byp ? 2 : 7;
    line_pos = 1'b0; line_neg = 1'b0; loop_pos = 1'b0; loop_neg = 1'b0;
    mode_b3zs = s.b3; dec_bypass = s.byp; loop_en = s.lp;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 16 + lat; c++) begin
      @(negedge clk);
      if (c >= lat) begin
        int k;
        logic [3:0] got, exp;
        k = c - lat;
        got = {dec_pos, dec_neg, dec_nrz, viol};
        exp = {s.ep[15-k], s.en[15-k], s.ep[15-k] | s.en[15-k], s.ev[15-k]};
        checks++;
        if (got !== exp) begin
          errors++;
          $display("FAIL %s bit %0d: actual p/n/nrz/v=%b expected %b", tag, k, got, exp);
        end
      end
      if (c < 16) drive_bit(s.lp, s.ip[15-c], s.inn[15-c]);
      else        drive_bit(s.lp, 1'b0, 1'b0);
    end
  endtask

  task automatic check1(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual p/n/nrz/v=%b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    // R10 reset state with busy inputs
    line_pos = 1'b1; line_neg = 1'b1; loop_pos = 1'b1; loop_neg = 1'b1;
    repeat (4) @(negedge clk);
    check1("R10 reset outputs", {dec_pos, dec_neg, dec_nrz, viol}, 4'b0000);

    // table walk
    for (int i = 0; i < NSEG; i++) run_stream(SEGS[i], seg_tag(i));

    // R7 exact enabled latency: single mark, output moves on the 7th edge
    line_pos = 1'b0; line_neg = 1'b0;
    mode_b3zs = 1'b1; dec_bypass = 1'b0; loop_en = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 9; c++) begin
      @(negedge clk);
      if (c == 6) check1("R7 before latency", {dec_pos, dec_neg, dec_nrz, viol}, 4'b0000);
      if (c == 7) check1("R7 at latency",     {dec_pos, dec_neg, dec_nrz, viol}, 4'b1010);
      line_pos = (c == 0);
    end

    // R10 stale polarity: + stream, reset, then spaces and + (first mark)
    run_stream('{1'b0, 1'b0, 1'b0, 16'b1000000000000000, 16'b0,
                 16'b1000000000000000, 16'b0, 16'b0000010000000000}, "R5 pre");
    run_stream('{1'b0, 1'b0, 1'b0, 16'b0000001000000000, 16'b0,
                 16'b0000001000000000, 16'b0, 16'b0000000000010000}, "R10/R5");
    // same in bypass: first mark after reset not flagged
    run_stream('{1'b1, 1'b1, 1'b0, 16'b0010000000000000, 16'b0,
                 16'b0010000000000000, 16'b0, 16'b0}, "R10/R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual hung, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule